// File: doc/BRIEF.md
# Virtualizable Interrupt Pending Status Register

This block is a read-only 64-bit status register that reports whether a normal interrupt, a fast interrupt or an asynchronous system error is pending. Each of the three flags shows either the physical pending line or the matching virtual pending line. The source is picked from the current privilege level, the security state, a secure-hypervisor enable and one hypervisor override bit for each class. When the system error is configured as edge-triggered, an internal latch holds it. The latch sets on a rising edge of the physical error line and clears when the exception entry logic reports that the error was taken.

Reads come in on a system-register request port that carries a packed 16-bit identifier. For a read that matches, the block gives one of three outcomes in the same cycle as the valid strobe: read data, an undefined-instruction fault, or a trap to privilege level 2 with syndrome class 0x18. The trap is requested by a fine-grained read-trap control. A 32-bit alias view returns the low half of the register.

Top module: `pend_status_reg`

## Requirements
- R1: Read data places the system-error flag at bit 8, the normal interrupt flag at bit 7 and the fast interrupt flag at bit 6. All other bits of a 64-bit read are zero.
- R2: At level 2 or level 3 (`cur_el` = 2 or 3), and at secure level 1 (`nonsecure`=0) with `sec_hyp_en`=0, every flag shows its physical source. This holds whatever the override bits are.
- R3: At non-secure level 1, or at secure level 1 with `sec_hyp_en`=1, each flag shows its virtual line when its override bit is 1 and its physical line when that bit is 0. The override bits are `hyp_ovr[2]`=error, `hyp_ovr[1]`=normal and `hyp_ovr[0]`=fast.
- R4: With `req_alias32`=1, bits 63:32 of `rd_data` are zero and bits 31:0 equal the 64-bit view.
- R5: A read at level 0 raises `rd_undef`, and `rd_data` is zero.
- R6: A level 1 read raises `rd_trap`, with `trap_class`=0x18 and `rd_data` zero, when three conditions all hold: `el2_enabled`=1, `el3_present`=0 or `fgt_en`=1, and `fgt_rd_trap`=1. If any of them fails, the read returns data.
- R7: Reads at levels 2 and 3 never trap.
- R8: Only the identifier 0xC608 (op0=3, op1=0, CRn=12, CRm=1, op2=0, packed from MSB to LSB) addresses the block. Any other identifier gives no outcome and zero data.
- R9: With `serr_edge_mode`=1, the physical error source is a latch that reads 1 from the clock edge that samples a rising edge of `phys_serr`. It stays 1 after the line drops, and a one-cycle `serr_taken` pulse clears it. With `serr_edge_mode`=0, the source follows `phys_serr` directly.
- R10: If a rising edge and `serr_taken` are seen in the same cycle, the latch ends set.
- R11: Every valid read that matches asserts exactly one of `rd_ok`, `rd_undef` and `rd_trap`, in the same cycle as `req_valid`.
- R12: A write (`req_write`=1) that matches raises `rd_undef` and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phys_irq | input | 1 | Physical normal interrupt pending |
| phys_fiq | input | 1 | Physical fast interrupt pending |
| phys_serr | input | 1 | Physical system error pending line |
| virt_irq | input | 1 | Virtual normal interrupt pending |
| virt_fiq | input | 1 | Virtual fast interrupt pending |
| virt_serr | input | 1 | Virtual system error pending |
| serr_edge_mode | input | 1 | 1: system error is edge-triggered and latched |
| serr_taken | input | 1 | One-cycle pulse: physical system error taken |
| cur_el | input | 2 | Current privilege level 0..3 |
| nonsecure | input | 1 | 1: non-secure state |
| sec_hyp_en | input | 1 | Secure hypervisor enable |
| hyp_ovr | input | 3 | Per-class override {error, normal, fast} |
| el2_enabled | input | 1 | Level 2 is enabled in the current state |
| el3_present | input | 1 | Level 3 is implemented |
| fgt_en | input | 1 | Level 3 fine-grained trap enable |
| fgt_rd_trap | input | 1 | Fine-grained read-trap bit for this register |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | 1: write access |
| req_id | input | 16 | Packed register identifier |
| req_alias32 | input | 1 | 1: 32-bit alias view |
| rd_ok | output | 1 | Read returns data |
| rd_undef | output | 1 | Undefined-instruction fault |
| rd_trap | output | 1 | Trap to level 2 |
| trap_class | output | 6 | Syndrome class, 0x18 on trap, else 0 |
| rd_data | output | 64 | Read data |

## Verification
Every read outcome and every data bit is combinational, so it is due in the same cycle as `req_valid`. The bench drives request inputs after a falling edge and samples them one time unit later, before the next rising edge. The error latch is the only registered result. It is due after the first rising edge that samples the stimulus, so the bench moves its inputs on a falling edge and reads back at the next falling edge. It checks that the latch keeps its value across further edges until the clearing pulse is sampled.

// File: rtl/pend_status_reg.sv
module pend_status_reg #(
  parameter logic [15:0] REG_ID    = 16'hC608,
  parameter logic [5:0]  TRAP_EC   = 6'h18,
  parameter int          DATA_W    = 64,
  parameter int          ALIAS_W   = 32,
  parameter int          BIT_SERR  = 8,
  parameter int          BIT_IRQ   = 7,
  parameter int          BIT_FIQ   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phys_irq,
  input  logic              phys_fiq,
  input  logic              phys_serr,
  input  logic              virt_irq,
  input  logic              virt_fiq,
  input  logic              virt_serr,
  input  logic              serr_edge_mode,
  input  logic              serr_taken,
  input  logic [1:0]        cur_el,
  input  logic              nonsecure,
  input  logic              sec_hyp_en,
  input  logic [2:0]        hyp_ovr,
  input  logic              el2_enabled,
  input  logic              el3_present,
  input  logic              fgt_en,
  input  logic              fgt_rd_trap,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [15:0]       req_id,
  input  logic              req_alias32,
  output logic              rd_ok,
  output logic              rd_undef,
  output logic              rd_trap,
  output logic [5:0]        trap_class,
  output logic [DATA_W-1:0] rd_data
);

  logic serr_prev, serr_lat, past_ok;
  logic serr_rise, serr_src;

  assign serr_rise = phys_serr & ~serr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      serr_prev <= 1'b0;
      serr_lat  <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      serr_prev <= phys_serr;
      past_ok   <= 1'b1;
      if (serr_rise)       serr_lat <= 1'b1;
      else if (serr_taken) serr_lat <= 1'b0;
    end
  end

  assign serr_src = serr_edge_mode ? serr_lat : phys_serr;

  logic       virt_ok;
  logic [2:0] sel_v;
  logic [2:0] pend;

  assign virt_ok = (cur_el == 2'd1) && (nonsecure || sec_hyp_en);
  assign sel_v   = virt_ok ? hyp_ovr : 3'b000;
  assign pend[2] = sel_v[2] ? virt_serr : serr_src;
  assign pend[1] = sel_v[1] ? virt_irq  : phys_irq;
  assign pend[0] = sel_v[0] ? virt_fiq  : phys_fiq;

  logic hit, trap_cond;
  logic [DATA_W-1:0] value;

  assign hit       = req_valid && (req_id == REG_ID);
  assign trap_cond = (cur_el == 2'd1) && el2_enabled &&
                     (!el3_present || fgt_en) && fgt_rd_trap;

  assign rd_undef  = hit && (req_write || cur_el == 2'd0);
  assign rd_trap   = hit && !rd_undef && trap_cond;
  assign rd_ok     = hit && !rd_undef && !trap_cond;
  assign trap_class = rd_trap ? TRAP_EC : 6'd0;

  always_comb begin
    value = '0;
    value[BIT_SERR] = pend[2];
    value[BIT_IRQ]  = pend[1];
    value[BIT_FIQ]  = pend[0];
    if (req_alias32) value[DATA_W-1:ALIAS_W] = '0;
  end

  assign rd_data = rd_ok ? value : '0;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_id == REG_ID) |-> $countones({rd_ok, rd_undef, rd_trap}) == 1); // R11
  AST_NO_HIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_id != REG_ID) |-> !(rd_ok || rd_undef || rd_trap) && rd_data == '0); // R8
  AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_id == REG_ID && cur_el == 2'd0) |-> rd_undef && rd_data == '0); // R5
  AST_HIGH_EL_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_el[1]) |-> !rd_trap); // R7
  AST_RES0: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[5:0] == '0 && rd_data[DATA_W-1:9] == '0); // R1
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(phys_serr && !serr_prev)) |-> serr_lat); // R10
  AST_TAKEN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(serr_taken && !(phys_serr && !serr_prev))) |-> !serr_lat); // R9

endmodule

// File: tb/sim_pend_status_reg.sv
module sim_pend_status_reg;
  logic clk = 0, rst_n = 0;
  logic phys_irq = 0, phys_fiq = 0, phys_serr = 0;
  logic virt_irq = 0, virt_fiq = 0, virt_serr = 0;
  logic serr_edge_mode = 0, serr_taken = 0;
  logic [1:0] cur_el = 3;
  logic nonsecure = 1, sec_hyp_en = 0;
  logic [2:0] hyp_ovr = 0;
  logic el2_enabled = 0, el3_present = 0, fgt_en = 0, fgt_rd_trap = 0;
  logic req_valid = 0, req_write = 0, req_alias32 = 0;
  logic [15:0] req_id = 0;
  logic rd_ok, rd_undef, rd_trap;
  logic [5:0] trap_class;
  logic [63:0] rd_data;
  int n_run = 0, n_fail = 0;
  localparam logic [15:0] ID = 16'hC608;

  always #5 clk = ~clk;

  pend_status_reg u0 (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] el, logic wr, logic [15:0] id, logic al);
    @(negedge clk);
    cur_el = el; req_write = wr; req_id = id; req_alias32 = al; req_valid = 1;
    #1;
  endtask

  function automatic logic [63:0] img(logic s, logic i, logic f);
    return ({55'd0, s, i, f, 6'd0});
  endfunction

  task automatic t_reset();
    req_valid = 0;
    #1;
    chk("R11 reset outcomes", {rd_ok, rd_undef, rd_trap}, 0);
    chk("R1 reset data", rd_data, 0);
  endtask

  task automatic t_phys();
    phys_irq = 1; phys_fiq = 0; phys_serr = 1;
    virt_irq = 0; virt_fiq = 1; virt_serr = 0; hyp_ovr = 3'b111;
    rd(3, 0, ID, 0);
    chk("R1 R2 el3 layout", rd_data, img(1, 1, 0));
    rd(2, 0, ID, 0);
    chk("R2 el2 phys", rd_data, img(1, 1, 0));
    nonsecure = 0; sec_hyp_en = 0;
    rd(1, 0, ID, 0);
    chk("R2 secure el1 phys", rd_data, img(1, 1, 0));
    nonsecure = 1;
  endtask

  task automatic t_virt();
    phys_irq = 1; phys_fiq = 0; phys_serr = 1;
    virt_irq = 0; virt_fiq = 1; virt_serr = 0;
    hyp_ovr = 3'b111;
    rd(1, 0, ID, 0);
    chk("R3 ns el1 all virt", rd_data, img(0, 0, 1));
    hyp_ovr = 3'b010;
    rd(1, 0, ID, 0);
    chk("R3 ns el1 irq virt only", rd_data, img(1, 0, 0));
    nonsecure = 0; sec_hyp_en = 1; hyp_ovr = 3'b101;
    rd(1, 0, ID, 0);
    chk("R3 secure el1 hyp en", rd_data, img(0, 1, 1));
    nonsecure = 1; sec_hyp_en = 0; hyp_ovr = 0;
  endtask

  task automatic t_alias();
    phys_irq = 1; phys_fiq = 1; phys_serr = 1;
    rd(3, 0, ID, 1);
    chk("R4 alias data", rd_data, img(1, 1, 1));
    chk("R4 alias high", {32'd0, rd_data[63:32]}, 0);
  endtask

  task automatic t_el0();
    rd(0, 0, ID, 0);
    chk("R5 el0 undef", {rd_ok, rd_undef, rd_trap}, 3'b010);
    chk("R5 el0 data", rd_data, 0);
  endtask

  task automatic t_trap();
    el2_enabled = 1; el3_present = 1; fgt_en = 1; fgt_rd_trap = 1;
    rd(1, 0, ID, 0);
    chk("R6 trap outcome", {rd_ok, rd_undef, rd_trap}, 3'b001);
    chk("R6 trap class", trap_class, 6'h18);
    chk("R6 trap data", rd_data, 0);
    el3_present = 0; fgt_en = 0;
    rd(1, 0, ID, 0);
    chk("R6 trap no el3", {rd_ok, rd_undef, rd_trap}, 3'b001);
    el3_present = 1; fgt_en = 0;
    rd(1, 0, ID, 0);
    chk("R6 fgt off no trap", {rd_ok, rd_undef, rd_trap}, 3'b100);
    fgt_en = 1; el2_enabled = 0;
    rd(1, 0, ID, 0);
    chk("R6 el2 off no trap", {rd_ok, rd_undef, rd_trap}, 3'b100);
    el2_enabled = 1; fgt_rd_trap = 0;
    rd(1, 0, ID, 0);
    chk("R6 bit clear no trap", {rd_ok, rd_undef, rd_trap}, 3'b100);
    fgt_rd_trap = 1;
    rd(2, 0, ID, 0);
    chk("R7 el2 no trap", {rd_ok, rd_undef, rd_trap}, 3'b100);
    rd(3, 0, ID, 0);
    chk("R7 el3 no trap", {rd_ok, rd_undef, rd_trap}, 3'b100);
    chk("R11 trap class zero on ok", trap_class, 0);
    el2_enabled = 0; el3_present = 0; fgt_en = 0; fgt_rd_trap = 0;
  endtask

  task automatic t_other_id();
    rd(3, 0, 16'hC609, 0);
    chk("R8 other id outcomes", {rd_ok, rd_undef, rd_trap}, 0);
    chk("R8 other id data", rd_data, 0);
    rd(0, 1, 16'h4608, 0);
    chk("R8 other id el0 write", {rd_ok, rd_undef, rd_trap}, 0);
  endtask

  task automatic t_write();
    serr_edge_mode = 1;
    rd(3, 1, ID, 0);
    chk("R12 write undef", {rd_ok, rd_undef, rd_trap}, 3'b010);
    chk("R12 write data", rd_data, 0);
    rd(3, 0, ID, 0);
    chk("R12 state unchanged", rd_data[8], phys_serr === 1 ? 1 : 0);
    serr_edge_mode = 0;
  endtask

  task automatic t_edge();
    phys_irq = 0; phys_fiq = 0; phys_serr = 0;
    @(negedge clk); @(negedge clk);
    serr_taken = 1; @(negedge clk); serr_taken = 0;
    serr_edge_mode = 1;
    rd(3, 0, ID, 0);
    chk("R9 latch idle", rd_data, 0);
    @(negedge clk); phys_serr = 1;
    @(negedge clk); #1;
    chk("R9 latch set", rd_data[8], 1);
    phys_serr = 0;
    @(negedge clk); @(negedge clk); #1;
    chk("R9 latch holds", rd_data[8], 1);
    serr_taken = 1;
    @(negedge clk); serr_taken = 0; #1;
    chk("R9 latch cleared", rd_data[8], 0);
    serr_taken = 1; phys_serr = 1;
    @(negedge clk); serr_taken = 0; #1;
    chk("R10 set wins", rd_data[8], 1);
    serr_edge_mode = 0; phys_serr = 0; #1;
    chk("R9 level mode follows", rd_data[8], 0);
    phys_serr = 1; #1;
    chk("R9 level mode high", rd_data[8], 1);
    phys_serr = 0;
    serr_taken = 1; @(negedge clk); serr_taken = 0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_phys();
    t_virt();
    t_alias();
    t_el0();
    t_trap();
    t_other_id();
    t_write();
    t_edge();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule